// File: doc/BRIEF.md
# Page ECC status evaluator

This block judges the outcome of one page read from a NAND device. It holds off until the flash event word reports that the read is complete. If that word also carries a flash timeout, the block reports a fatal timeout at once. Otherwise it takes in the page's main data area as a byte stream and notes whether every byte reads as erased (0xFF). It then walks the sectors of the page one at a time, reading each sector's error count out of a bank of packed 32-bit ECC status words.

A sector whose error count says "uncorrectable" is the only failure case. Blank pages always fail the hardware ECC check, so a failing sector on a fully erased page is reported as blank and the walk stops there. A failing sector on a page that holds data raises a fatal ECC flag, which stays set. Each evaluation ends with a single-cycle result strobe. In the same cycle the block issues a write-one-to-clear of the event bits it saw.

A controller starts one evaluation per page with `start`. It passes the buffer number and the page-size code, then supplies the event word, the ECC words and the data stream.

Top module: `page_ecc_eval`

## Requirements
- R1: While reset is held and right after it, `res_valid`, `done`, `blank`, `ecc_fatal`, `timeout_fatal`, `evt_clr`, `byte_ready` are 0 and `evt_clr_mask` is 0.
- R2: After `start`, the block neither accepts bytes nor reports a result until bit 31 (operation complete) of `evt_stat` is 1.
- R3: If bit 31 and bit 30 (flash timeout) of `evt_stat` are both 1 when completion is first seen, the result has `done`=1 and `timeout_fatal`=1, and no byte is consumed.
- R4: Sector n's error count is the 4-bit field at bits [(3 - n mod 4)*8 + 3 : (3 - n mod 4)*8] of status word n/4 (word k occupies `ecc_stat` bits [32k+31:32k]). The value 0xF means uncorrectable. Every other value, including 0xE and a byte whose upper nibble is 0xF, counts as good.
- R5: `page_sel` 0, 1, 2, 3 selects 512, 2048, 4096, 8192 bytes, which is 1, 4, 8, 16 sectors. The sectors checked are buf_num*count through buf_num*count + count - 1, and sectors outside that range have no effect.
- R6: An uncorrectable sector on a page whose bytes are all 0xFF gives `blank`=1 and `done`=1, with `ecc_fatal` unchanged.
- R7: An uncorrectable sector on a page with any byte other than 0xFF sets `ecc_fatal`. It stays 1 through later evaluations until reset.
- R8: With no uncorrectable sector in range, the result has `done`=1, `blank`=0 and `timeout_fatal`=0, even for an all-0xFF page.
- R9: `evt_clr` is 1 exactly in the `res_valid` cycle, and `evt_clr_mask` then equals the `evt_stat` value seen when completion was detected.
- R10: Outside a timeout, exactly page-size bytes are accepted per evaluation, one per cycle when `byte_valid` and `byte_ready` are both 1. No result is reported while `byte_ready` is 1.
- R11: `res_valid` is a one-cycle pulse, and `done`, `blank`, `timeout_fatal` are 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (taken when idle) |
| buf_num | input | 5 | Buffer number of the page |
| page_sel | input | 2 | Page-size code: 0=512, 1=2048, 2=4096, 3=8192 |
| ecc_stat | input | 256 | Eight packed ECC status words |
| evt_stat | input | 32 | Event status: bit 31 complete, bit 30 timeout |
| byte_valid | input | 1 | Page data byte offered |
| byte_data | input | 8 | Page data byte |
| byte_ready | output | 1 | Block accepts a data byte |
| res_valid | output | 1 | Result strobe |
| done | output | 1 | Evaluation completed |
| blank | output | 1 | Page judged erased |
| ecc_fatal | output | 1 | Sticky uncorrectable-data flag |
| timeout_fatal | output | 1 | Flash timeout observed |
| evt_clr | output | 1 | Write-one-to-clear strobe for event bits |
| evt_clr_mask | output | 32 | Event bits to clear |

## Verification
The bench targets the nibble position inside each status byte. A design that read the wrong nibble, or mirrored the byte order, would flag a 0xF0 byte as a failure or miss a real 0xF field. It checks sectors just outside the page's range, which a wrong start index or count would wrongly include. It also places a non-0xFF byte as the very last byte of an 8 KiB page, where a scan that stopped one byte early would call the page blank instead of fatal. Further stimulus covers a long wait before completion, a timeout with no data phase, and a good page after a fatal one. Those catch early acceptance of bytes, consumption during a timeout, and a fatal flag that clears on its own.

// File: rtl/page_ecc_pkg.sv
`timescale 1ns/1ps
package page_ecc_pkg;
  localparam int SECTOR_BYTES = 512;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SCAN, ST_EVAL, ST_REPORT
  } eval_state_e;

  typedef enum logic [1:0] {
    RES_OK, RES_BLANK, RES_FATAL, RES_TIMEOUT
  } res_kind_e;

  // log2 of sectors per page for each page-size code
  function automatic logic [2:0] sectors_lg2(input logic [1:0] psel);
    case (psel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ecc_field_pick.sv
`timescale 1ns/1ps
module ecc_field_pick #(
  parameter int NUM_WORDS = 8,
  localparam int NUM_SEC = NUM_WORDS * 4,
  localparam int IDX_W = $clog2(NUM_SEC)
) (
  input  logic [NUM_WORDS*32-1:0] stat_flat,
  input  logic [IDX_W-1:0]        idx,
  output logic [3:0]              count,
  output logic                    uncorr
);
  logic [3:0]           nib [NUM_SEC];
  logic [NUM_SEC*4-1:0] unused_hi;

  // lowest sector of a word sits in its most significant byte
  for (genvar g = 0; g < NUM_SEC; g++) begin : g_nib
    localparam int LSB = (g / 4) * 32 + (3 - (g % 4)) * 8;
    assign nib[g]            = stat_flat[LSB +: 4];
    assign unused_hi[g*4 +: 4] = stat_flat[LSB + 4 +: 4];
  end

  assign count  = nib[idx];
  assign uncorr = (count == 4'hF);
endmodule

// File: rtl/erased_scan.sv
`timescale 1ns/1ps
module erased_scan #(
  parameter int MAX_BYTES = 8192,
  localparam int CNT_W = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fire,
  input  logic [7:0]       data,
  input  logic [CNT_W-1:0] limit_m1,
  output logic             all_ff,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ff_q, ff_d;

  always_comb begin
    cnt_d = cnt_q;
    ff_d  = ff_q;
    if (clear) begin
      cnt_d = '0;
      ff_d  = 1'b1;
    end else if (fire) begin
      cnt_d = cnt_q + 1'b1;
      ff_d  = ff_q & (data == 8'hFF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ff_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      ff_q  <= ff_d;
    end
  end

  assign all_ff = ff_q;
  assign last   = fire && (cnt_q == limit_m1);
endmodule

// File: rtl/page_ecc_eval.sv
`timescale 1ns/1ps
module page_ecc_eval
  import page_ecc_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int MAX_PAGE  = 8192,
  parameter int OPC_BIT   = 31,
  parameter int FTO_BIT   = 30,
  localparam int NUM_SEC = NUM_WORDS * 4,
  localparam int IDX_W   = $clog2(NUM_SEC),
  localparam int CNT_W   = $clog2(MAX_PAGE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IDX_W-1:0]        buf_num,
  input  logic [1:0]              page_sel,
  input  logic [NUM_WORDS*32-1:0] ecc_stat,
  input  logic [31:0]             evt_stat,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  output logic                    byte_ready,
  output logic                    res_valid,
  output logic                    done,
  output logic                    blank,
  output logic                    ecc_fatal,
  output logic                    timeout_fatal,
  output logic                    evt_clr,
  output logic [31:0]             evt_clr_mask
);
  eval_state_e             state_q, state_d;
  res_kind_e               kind_q, kind_d;
  logic [IDX_W-1:0]        buf_q, buf_d;
  logic [2:0]              lg_q, lg_d;
  logic [NUM_WORDS*32-1:0] stat_q, stat_d;
  logic [31:0]             evt_q, evt_d;
  logic [IDX_W-1:0]        sec_q, sec_d;
  logic                    fatal_q, fatal_d;

  logic [IDX_W-1:0] first_idx, sec_end, spp_m1;
  logic [IDX_W:0]   spp;
  logic [CNT_W:0]   pbytes;
  logic [CNT_W-1:0] page_m1;
  logic             scan_clear, scan_fire, scan_last, scan_all_ff;
  logic [3:0]       sec_count;
  logic             sec_uncorr;

  // page geometry from latched buffer number and size code
  assign spp       = (IDX_W+1)'(1) << lg_q;
  assign spp_m1    = IDX_W'(spp - 1'b1);
  assign first_idx = buf_q << lg_q;
  assign sec_end   = first_idx + spp_m1;
  assign pbytes    = (CNT_W+1)'(SECTOR_BYTES) << lg_q;
  assign page_m1   = CNT_W'(pbytes - 1'b1);

  assign byte_ready = (state_q == ST_SCAN);
  assign scan_fire  = byte_valid && byte_ready;
  assign scan_clear = (state_q == ST_IDLE) && start;

  erased_scan #(.MAX_BYTES(MAX_PAGE)) u_scan (
    .clk(clk), .rst_n(rst_n), .clear(scan_clear), .fire(scan_fire),
    .data(byte_data), .limit_m1(page_m1),
    .all_ff(scan_all_ff), .last(scan_last)
  );

  ecc_field_pick #(.NUM_WORDS(NUM_WORDS)) u_pick (
    .stat_flat(stat_q), .idx(sec_q), .count(sec_count), .uncorr(sec_uncorr)
  );

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    buf_d   = buf_q;
    lg_d    = lg_q;
    stat_d  = stat_q;
    evt_d   = evt_q;
    sec_d   = sec_q;
    fatal_d = fatal_q;
    case (state_q)
      ST_IDLE: if (start) begin
        buf_d   = buf_num;
        lg_d    = sectors_lg2(page_sel);
        state_d = ST_WAIT;
      end
      ST_WAIT: if (evt_stat[OPC_BIT]) begin
        evt_d  = evt_stat;
        stat_d = ecc_stat;
        if (evt_stat[FTO_BIT]) begin
          kind_d  = RES_TIMEOUT;
          state_d = ST_REPORT;
        end else begin
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: if (scan_last) begin
        sec_d   = first_idx;
        state_d = ST_EVAL;
      end
      ST_EVAL: begin
        if (sec_uncorr) begin
          kind_d  = scan_all_ff ? RES_BLANK : RES_FATAL;
          fatal_d = fatal_q | ~scan_all_ff;
          state_d = ST_REPORT;
        end else if (sec_q == sec_end) begin
          kind_d  = RES_OK;
          state_d = ST_REPORT;
        end else begin
          sec_d = sec_q + 1'b1;
        end
      end
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= RES_OK;
      buf_q   <= '0;
      lg_q    <= '0;
      stat_q  <= '0;
      evt_q   <= '0;
      sec_q   <= '0;
      fatal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      buf_q   <= buf_d;
      lg_q    <= lg_d;
      stat_q  <= stat_d;
      evt_q   <= evt_d;
      sec_q   <= sec_d;
      fatal_q <= fatal_d;
    end
  end

  assign res_valid     = (state_q == ST_REPORT);
  assign done          = res_valid;
  assign blank         = res_valid && (kind_q == RES_BLANK);
  assign timeout_fatal = res_valid && (kind_q == RES_TIMEOUT);
  assign ecc_fatal     = fatal_q;
  assign evt_clr       = res_valid;
  assign evt_clr_mask  = res_valid ? evt_q : 32'h0;
endmodule

// File: rtl/page_ecc_eval_chk.sv
`timescale 1ns/1ps
module page_ecc_eval_chk #(
  parameter int OPC_BIT = 31,
  parameter int FTO_BIT = 30
) (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_ready,
  input logic        res_valid,
  input logic        done,
  input logic        blank,
  input logic        ecc_fatal,
  input logic        timeout_fatal,
  input logic        evt_clr,
  input logic [31:0] evt_clr_mask
);
  // R11
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R11
  quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!done && !blank && !timeout_fatal));
  // R9
  clear_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (evt_clr && evt_clr_mask[OPC_BIT]));
  // R3
  timeout_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && timeout_fatal) |-> (evt_clr_mask[FTO_BIT] && !blank));
  // R6
  blank_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && blank) |-> !evt_clr_mask[FTO_BIT]);
  // R7
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_fatal |=> ecc_fatal);
  // R10
  no_result_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !res_valid);
endmodule

bind page_ecc_eval page_ecc_eval_chk #(.OPC_BIT(OPC_BIT), .FTO_BIT(FTO_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_ready(byte_ready), .res_valid(res_valid),
  .done(done), .blank(blank), .ecc_fatal(ecc_fatal),
  .timeout_fatal(timeout_fatal), .evt_clr(evt_clr), .evt_clr_mask(evt_clr_mask)
);

// File: tb/sim_page_ecc_eval.sv
`timescale 1ns/1ps
module sim_page_ecc_eval;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [4:0]   buf_num;
  logic [1:0]   page_sel;
  logic [255:0] ecc_stat;
  logic [31:0]  evt_stat;
  logic         byte_valid;
  logic [7:0]   byte_data;
  logic         byte_ready, res_valid, done, blank, ecc_fatal, timeout_fatal, evt_clr;
  logic [31:0]  evt_clr_mask;

  int tests = 0;
  int fails = 0;
  int acc_bytes = 0;
  bit exp_sticky = 0;

  always #2 clk = ~clk;

  page_ecc_eval u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_num(buf_num), .page_sel(page_sel),
    .ecc_stat(ecc_stat), .evt_stat(evt_stat), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .res_valid(res_valid),
    .done(done), .blank(blank), .ecc_fatal(ecc_fatal), .timeout_fatal(timeout_fatal),
    .evt_clr(evt_clr), .evt_clr_mask(evt_clr_mask)
  );

  always @(posedge clk) if (byte_valid && byte_ready) acc_bytes++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // 0 ok, 1 blank, 2 fatal
  function automatic int exp_kind(input logic [255:0] st, input int bn, input int ps, input bit allff);
    int lg, spp, first;
    logic [3:0] f;
    lg = (ps == 0) ? 0 : ps + 1;
    spp = 1 << lg;
    first = bn * spp;
    for (int s = first; s < first + spp; s++) begin
      f = st[(s / 4) * 32 + (3 - s % 4) * 8 +: 4];
      if (f == 4'hF) return allff ? 1 : 2;
    end
    return 0;
  endfunction

  function automatic logic [255:0] put_field(input logic [255:0] st, input int s, input logic [3:0] v);
    logic [255:0] r;
    r = st;
    r[(s / 4) * 32 + (3 - s % 4) * 8 +: 4] = v;
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 0; buf_num = 0; page_sel = 0; ecc_stat = '0;
    evt_stat = 0; byte_valid = 0; byte_data = 0;
    repeat (3) @(negedge clk);
    chk(!res_valid && !done && !blank && !ecc_fatal && !timeout_fatal && !evt_clr &&
        !byte_ready && evt_clr_mask == 0, "R1 during reset",
        {res_valid, done, blank, ecc_fatal, timeout_fatal, evt_clr, byte_ready}, 0);
    rst_n = 1'b1;
    exp_sticky = 0;
    @(negedge clk);
    chk(!res_valid && !ecc_fatal && !byte_ready && evt_clr_mask == 0, "R1 after reset",
        {res_valid, ecc_fatal, byte_ready}, 0);
  endtask

  task automatic run_op(input logic [255:0] st, input int bn, input int ps, input int bad_pos,
                        input int opc_dly, input bit fto, input string tag);
    int lg, pbytes, kind, waitc;
    bit early;
    logic [31:0] ev;
    string rq;
    lg = (ps == 0) ? 0 : ps + 1;
    pbytes = 512 << lg;
    kind = fto ? 3 : exp_kind(st, bn, ps, bad_pos < 0);
    if (kind == 2) exp_sticky = 1;
    rq = (kind == 0) ? "R8" : (kind == 1) ? "R6" : (kind == 2) ? "R7" : "R3";
    @(negedge clk);
    acc_bytes = 0;
    ecc_stat = st; buf_num = 5'(bn); page_sel = 2'(ps); evt_stat = 0; start = 1;
    @(negedge clk);
    start = 0;
    early = 0;
    for (int k = 0; k < opc_dly; k++) begin
      if (byte_ready || res_valid) early = 1;
      @(negedge clk);
    end
    if (opc_dly > 0) chk(!early, {"R2 waited for completion ", tag}, early, 0);
    ev = {1'b1, fto, 30'($urandom)};
    evt_stat = ev;
    if (!fto) begin
      for (int i = 0; i < pbytes; i++) begin
        if ($urandom % 8 == 0) begin
          byte_valid = 0;
          @(negedge clk);
        end
        byte_valid = 1;
        byte_data = (i == bad_pos) ? 8'($urandom % 255) : 8'hFF;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
      end
      byte_valid = 0;
    end
    waitc = 0;
    while (!res_valid && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    chk(res_valid && done, {"R11 result strobe ", tag}, {res_valid, done}, 2'b11);
    chk(blank == (kind == 1) && timeout_fatal == (kind == 3), {rq, " result kind ", tag},
        {blank, timeout_fatal}, {kind == 1, kind == 3});
    chk(ecc_fatal == exp_sticky, {"R7 fatal flag ", tag}, ecc_fatal, exp_sticky);
    chk(evt_clr && evt_clr_mask == ev, {"R9 clear mask ", tag}, evt_clr_mask, ev);
    chk(acc_bytes == (fto ? 0 : pbytes), {"R10 bytes taken ", tag}, acc_bytes, fto ? 0 : pbytes);
    @(negedge clk);
    chk(!res_valid && !done && !evt_clr, {"R11 single pulse ", tag}, {res_valid, done, evt_clr}, 0);
    evt_stat = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [255:0] st;
    void'($urandom(32'd4242));
    do_reset();

    // R2 R8: long wait, no failing sector, erased page stays ok
    run_op('0, 0, 1, -1, 20, 0, "d1");
    // R3: timeout skips data phase
    run_op('0, 3, 0, -1, 2, 1, "d2");
    // R4: upper nibble 0xF is not the count
    run_op({32{8'hF0}}, 5, 0, 100, 1, 0, "d3");
    // R4: sector 5 = word 1 bits 19:16
    run_op(put_field('0, 5, 4'hF), 5, 0, 0, 0, 0, "d4");
    do_reset();
    // R5: failing sectors 3 and 8 lie outside 4..7
    run_op(put_field(put_field('0, 3, 4'hF), 8, 4'hF), 1, 1, 7, 0, 0, "d5");
    // R6: failing sector 7 on erased page
    run_op(put_field('0, 7, 4'hF), 1, 1, -1, 0, 0, "d6");
    // R4: count 0xE everywhere is good
    run_op({64{4'hE}}, 2, 2, 5, 0, 0, "d7");
    // R7: last byte of an 8 KiB page non-erased, sector 31 failing
    run_op(put_field('0, 31, 4'hF), 1, 3, 8191, 0, 0, "d8");
    // R7: fatal flag survives a good evaluation
    run_op('0, 0, 0, 3, 0, 0, "d9");
    do_reset();
    chk(ecc_fatal == 0, "R7 cleared by reset", ecc_fatal, 0);
    // R6: single-sector page blank
    run_op(put_field('0, 0, 4'hF), 0, 0, -1, 0, 0, "d10");

    for (int n = 0; n < 16; n++) begin
      int ps, spp, bn, bad, lg;
      bit fto, clean;
      ps = int'($urandom % 4);
      lg = (ps == 0) ? 0 : ps + 1;
      spp = 1 << lg;
      bn = int'($urandom % (32 / spp));
      clean = ($urandom % 2) == 0;
      for (int s = 0; s < 32; s++)
        st = put_field(st, s, (!clean && $urandom % 4 == 0) ? 4'hF : 4'($urandom % 15));
      for (int w = 0; w < 8; w++)
        for (int b = 0; b < 4; b++)
          st[w * 32 + b * 8 + 4 +: 4] = 4'($urandom);
      bad = ($urandom % 2 == 0) ? -1 : int'($urandom % (512 << lg));
      fto = ($urandom % 8) == 0;
      run_op(st, bn, ps, bad, int'($urandom % 6), fto, "rnd R4 R5");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule